// File: doc/BRIEF.md
# Interrupt Request Latch and Dispatcher

This block sits between a set of interrupt request lines and a downstream interrupt controller. Each pin reports level changes as update events. The block keeps one pending-request bit per pin. It decides, from that pin's routing entry, whether and when a message is sent. A routing entry holds the vector, destination, delivery mode, trigger mode, mask and remote-pending bit. A message carries the vector, destination, delivery mode, trigger mode and source pin. It leaves on a valid/ready handshake, and the downstream side returns a hit flag, which it raises when at least one destination took the message.

The routing entries belong to a register file outside this block. That register file supplies the fields continuously, and it pulses a per-pin strobe whenever software writes an entry. When a level-mode message is accepted with a hit, this block raises a one-cycle set strobe for the remote-pending bit of that pin. The register file is expected to show the updated bit on the cycle after that strobe. End-of-interrupt handling stays in the register file.

Edge-mode pins coalesce repeated assertions while their pending bit stays set. Level-mode pins are re-attempted on every assertion, and they are held back while the remote-pending bit is set. For software, a pending view is provided in which edge requests that have already been delivered read as zero.

Top module: `irq_dispatch`

## Requirements
- R1: An update event with value 0 clears the pin's pending bit and cancels any dispatch attempt not yet loaded into the message register, so no message for that attempt is ever sent.
- R2: An edge-mode (trigger bit 0) update with value 1 that arrives while the pin's pending bit is already set pulses that pin's coalesce output on the next cycle and starts no dispatch attempt.
- R3: Every edge-mode update with value 1 clears the pin's delivered flag, and an accepted edge message sets it. The pending view equals pending AND NOT delivered.
- R4: An attempt made for a pin while its mask bit is set, or while it is in level mode (trigger bit 1) with remote-pending set, is dropped without a message. Clearing the gate later does not revive the attempt.
- R5: When a level-mode message is accepted (valid and ready) with hit high, the set strobe bit of that pin is high in that same cycle. An edge-mode message, or a message accepted with hit low, raises no set strobe.
- R6: A configuration write strobe for a pin that leaves it in level mode with its pending bit set starts a new dispatch attempt.
- R7: Among pins that are eligible together, the lowest-numbered pin is loaded first. At most one message is loaded per cycle, and a new message may load in the same cycle the previous one is accepted.
- R8: A valid message keeps all its fields stable until ready is seen. Pending bits keep tracking update events while the message waits.
- R9: After reset, no message is valid, and the pending view, the coalesce output and the set strobe are all zero.
- R10: A loaded message carries the vector, destination, delivery mode and trigger mode that the selected pin's entry held when the message was loaded, along with the pin's index.
- R11: A level-mode update with value 1 starts a dispatch attempt even when the pending bit is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_upd | input | N | Per-pin update event strobe |
| line_val | input | N | New line level carried with each update event |
| cfg_wr | input | N | Per-pin strobe: the entry was just written |
| cfg_mask | input | N | Per-pin mask bit |
| cfg_level | input | N | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_rirr | input | N | Per-pin remote-pending bit |
| cfg_vector | input | N*VW | Per-pin vector, pin i at bits [i*VW +: VW] |
| cfg_dest | input | N*DW | Per-pin destination, pin i at bits [i*DW +: DW] |
| cfg_dmode | input | N*3 | Per-pin delivery mode, pin i at bits [i*3 +: 3] |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream takes the message this cycle |
| msg_hit | input | 1 | At least one destination accepted, qualified by ready |
| msg_vector | output | VW | Message vector |
| msg_dest | output | DW | Message destination |
| msg_dmode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger mode |
| msg_pin | output | clog2(N) | Source pin of the message |
| rirr_set | output | N | Set strobe for remote-pending bits |
| coal | output | N | Coalesced-request pulse per pin |
| irr_rd | output | N | Pending view with delivered edge bits masked off |

## Verification
The bench goes after the gating cases. If an attempt that was masked or held back by remote-pending survived, the message would appear as soon as the gate opens. If coalescing were wrong, a second edge would produce a duplicate delivery, or the coalesce pulse would be missing. The level-mode cases are checked separately. A design that coalesced level pins would never redeliver after an end-of-interrupt. A design that ignored the write strobe would leave a pending level pin stuck once it is unmasked. The bench also checks cancellation by deassertion while the output is busy, lowest-pin ordering across back-to-back loads, and the set strobe with hit low. A design that got any of these wrong would send a wrong or extra message, or would drop a message it owes.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
  localparam int unsigned DMW = 3;
endpackage

// File: rtl/irqd_pin_state.sv
module irqd_pin_state
  import irqd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic val,
  input  logic lvl,
  input  logic mask,
  input  logic rirr,
  input  logic wr,
  input  logic take,
  input  logic edge_done,
  output logic irr_q,
  output logic dlv_q,
  output logic elig,
  output logic coal_q
);
  logic arm_q, arm_d, irr_d, dlv_d, coal_d, blocked, edge_assert;

  assign blocked     = mask | (lvl & rirr);
  assign elig        = arm_q & ~blocked;
  assign edge_assert = upd & val & (trig_e'(lvl) == TRIG_EDGE);
  assign irr_d       = upd ? val : irr_q;
  assign coal_d      = edge_assert & irr_q;

  always_comb begin
    arm_d = elig & ~take;
    if (upd) begin
      if (!val) arm_d = 1'b0;
      else if (lvl || !irr_q) arm_d = 1'b1;
    end
    if (wr && lvl && irr_d) arm_d = 1'b1;
  end

  always_comb begin
    dlv_d = dlv_q | edge_done;
    if (edge_assert) dlv_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= 1'b0;
      dlv_q  <= 1'b0;
      arm_q  <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      irr_q  <= irr_d;
      dlv_q  <= dlv_d;
      arm_q  <= arm_d;
      coal_q <= coal_d;
    end
  end

  // R1: a deassertion leaves nothing pending and nothing armed
  p_deassert_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !val) |=> (!irr_q && !elig));
  // R2: a coalesce pulse only follows while the request is still pending
  p_coal_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coal_q |-> irr_q);
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned PW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [PW-1:0] idx
);
  function automatic logic [PW-1:0] lowest_set(input logic [N-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign any = |req;
  assign idx = lowest_set(req);
endmodule

// File: rtl/irqd_msg_hold.sv
module irqd_msg_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q,
  output logic         can_load
);
  assign can_load = ~valid | ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8: an unaccepted message holds still
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(q)));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    line_upd,
  input  logic [N-1:0]    line_val,
  input  logic [N-1:0]    cfg_wr,
  input  logic [N-1:0]    cfg_mask,
  input  logic [N-1:0]    cfg_level,
  input  logic [N-1:0]    cfg_rirr,
  input  logic [N*VW-1:0] cfg_vector,
  input  logic [N*DW-1:0] cfg_dest,
  input  logic [N*DMW-1:0] cfg_dmode,
  output logic            msg_valid,
  input  logic            msg_ready,
  input  logic            msg_hit,
  output logic [VW-1:0]   msg_vector,
  output logic [DW-1:0]   msg_dest,
  output logic [DMW-1:0]  msg_dmode,
  output logic            msg_level,
  output logic [PW-1:0]   msg_pin,
  output logic [N-1:0]    rirr_set,
  output logic [N-1:0]    coal,
  output logic [N-1:0]    irr_rd
);
  localparam int unsigned MW = VW + DW + DMW + 1 + PW;

  logic [N-1:0]  elig_v, irr_v, dlv_v, take_v, edge_done_v;
  logic          any_elig, can_load, take, fire;
  logic [PW-1:0] sel_idx;
  logic [MW-1:0] load_word, held_word;

  assign fire = msg_valid & msg_ready;

  irqd_pick #(.N(N), .PW(PW)) u_pick (
    .req(elig_v), .any(any_elig), .idx(sel_idx)
  );

  assign take = can_load & any_elig;

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign take_v[i]      = take && (sel_idx == PW'(i));
    assign edge_done_v[i] = fire && (trig_e'(msg_level) == TRIG_EDGE) && (msg_pin == PW'(i));
    assign rirr_set[i]    = fire && (trig_e'(msg_level) == TRIG_LEVEL) && msg_hit
                            && (msg_pin == PW'(i));
    irqd_pin_state u_pin (
      .clk(clk), .rst_n(rst_n),
      .upd(line_upd[i]), .val(line_val[i]),
      .lvl(cfg_level[i]), .mask(cfg_mask[i]), .rirr(cfg_rirr[i]),
      .wr(cfg_wr[i]), .take(take_v[i]), .edge_done(edge_done_v[i]),
      .irr_q(irr_v[i]), .dlv_q(dlv_v[i]), .elig(elig_v[i]), .coal_q(coal[i])
    );
  end

  assign irr_rd = irr_v & ~dlv_v;

  assign load_word = {cfg_vector[sel_idx*VW +: VW], cfg_dest[sel_idx*DW +: DW],
                      cfg_dmode[sel_idx*DMW +: DMW], cfg_level[sel_idx], sel_idx};

  irqd_msg_hold #(.W(MW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(take), .d(load_word), .ready(msg_ready),
    .valid(msg_valid), .q(held_word), .can_load(can_load)
  );

  assign {msg_vector, msg_dest, msg_dmode, msg_level, msg_pin} = held_word;

  // R4: a pin is never loaded while masked
  p_take_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !cfg_mask[sel_idx]);
  // R7: no lower-numbered eligible pin is passed over
  p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((elig_v & ((N'(1) << sel_idx) - N'(1))) == '0));
  // R5: at most one set strobe, and only with a message present
  p_rirr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_set) |-> ($onehot0(rirr_set) && msg_valid));
  // R3: a delivered edge leaves its pending view clear until re-asserted
  p_edge_delivered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_done_v) && !(|(line_upd & edge_done_v)) |=> ((irr_rd & $past(edge_done_v)) == '0));
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int N = 8, VW = 8, DW = 8, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line_upd = '0, line_val = '0, cfg_wr = '0, cfg_mask = '0, cfg_level = '0, cfg_rirr = '0;
  logic [N*VW-1:0] cfg_vector;
  logic [N*DW-1:0] cfg_dest;
  logic [N*3-1:0]  cfg_dmode;
  logic msg_ready = 1'b0, msg_hit = 1'b1;
  logic msg_valid, msg_level;
  logic [VW-1:0] msg_vector;
  logic [DW-1:0] msg_dest;
  logic [2:0] msg_dmode;
  logic [PW-1:0] msg_pin;
  logic [N-1:0] rirr_set, coal, irr_rd;

  int checks = 0, failures = 0;

  // reference state
  bit m_irr[N], m_dlv[N], m_arm[N], m_coal[N];
  bit m_valid = 0, m_lvl = 0;
  int m_pin = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_cfg
    assign cfg_vector[g*VW +: VW] = 8'h20 + 8'(g);
    assign cfg_dest[g*DW +: DW]   = 8'(g * 3);
    assign cfg_dmode[g*3 +: 3]    = 3'(g + 1);
  end

  irq_dispatch #(.N(N), .VW(VW), .DW(DW)) uut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_view();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_irr[i] & ~m_dlv[i];
    return v;
  endfunction

  function automatic logic [N-1:0] m_rset();
    logic [N-1:0] v = '0;
    if (m_valid && msg_ready && m_lvl && msg_hit) v[m_pin] = 1'b1;
    return v;
  endfunction

  task automatic compare_model();
    logic [N-1:0] cv;
    for (int i = 0; i < N; i++) cv[i] = m_coal[i];
    check(msg_valid == m_valid, "R7 valid", msg_valid, m_valid);
    if (m_valid && msg_valid) begin
      check(msg_pin == PW'(m_pin), "R10 pin", msg_pin, m_pin);
      check(msg_vector == 8'h20 + 8'(m_pin), "R10 vector", msg_vector, 8'h20 + m_pin);
      check(msg_dest == 8'(m_pin * 3) && msg_dmode == 3'(m_pin + 1), "R10 dest/dmode",
            {msg_dest, msg_dmode}, {8'(m_pin * 3), 3'(m_pin + 1)});
      check(msg_level == m_lvl, "R10 level", msg_level, m_lvl);
    end
    check(irr_rd == m_view(), "R3 view", irr_rd, m_view());
    check(coal == cv, "R2 coal", coal, cv);
    check(rirr_set == m_rset(), "R5 rirr_set", rirr_set, m_rset());
  endtask

  task automatic model_step();
    bit fire, can, el[N];
    int sel = -1;
    fire = m_valid && msg_ready;
    can  = !m_valid || msg_ready;
    for (int i = 0; i < N; i++) begin
      el[i] = m_arm[i] && !cfg_mask[i] && !(cfg_level[i] && cfg_rirr[i]);
      if (el[i] && sel < 0) sel = i;
    end
    for (int i = 0; i < N; i++) begin
      bit na, ni, edge_up;
      edge_up = line_upd[i] && line_val[i] && !cfg_level[i];
      na = el[i] && !(can && sel == i);
      ni = line_upd[i] ? line_val[i] : m_irr[i];
      if (line_upd[i]) begin
        if (!line_val[i]) na = 0;
        else if (cfg_level[i] || !m_irr[i]) na = 1;
      end
      if (cfg_wr[i] && cfg_level[i] && ni) na = 1;
      m_coal[i] = edge_up && m_irr[i];
      if (fire && !m_lvl && m_pin == i) m_dlv[i] = 1;
      if (edge_up) m_dlv[i] = 0;
      m_arm[i] = na;
      m_irr[i] = ni;
    end
    if (fire && m_lvl && msg_hit) cfg_rirr[m_pin] = 1'b1;
    if (can && sel >= 0) begin
      m_valid = 1; m_pin = sel; m_lvl = cfg_level[sel];
    end else if (fire) m_valid = 0;
  endtask

  task automatic tick();
    #1;
    compare_model();
    @(posedge clk);
    #1;
    model_step();
    @(negedge clk);
    line_upd = '0;
    cfg_wr = '0;
  endtask

  task automatic ev(input int p, input bit v);
    line_upd[p] = 1'b1;
    line_val[p] = v;
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();
    // R9 reset state
    check(msg_valid == 0 && irr_rd == 0 && coal == 0 && rirr_set == 0, "R9 reset",
          {msg_valid, irr_rd, coal, rirr_set}, 0);

    // R10 / R8 / R3: edge pin 3, held while not ready
    ev(3, 1); tick(); tick();
    check(msg_valid && msg_pin == 3 && msg_vector == 8'h23, "R10 load pin3", msg_pin, 3);
    tick(); tick();
    check(msg_valid && msg_pin == 3, "R8 held", msg_valid, 1);
    check(irr_rd[3] == 1, "R3 pending before delivery", irr_rd[3], 1);
    msg_ready = 1'b1;
    check(rirr_set == 0, "R5 edge no strobe", rirr_set, 0);
    tick();
    check(!msg_valid && irr_rd[3] == 0, "R3 delivered masked", irr_rd[3], 0);

    // R2: repeated edge while pending
    ev(3, 1); tick();
    check(coal[3] == 1, "R2 coalesce pulse", coal[3], 1);
    check(irr_rd[3] == 1, "R3 assertion clears delivered", irr_rd[3], 1);
    tick();
    check(!msg_valid, "R2 no dispatch", msg_valid, 0);

    // R1: deassertion clears pending
    ev(3, 0); tick();
    check(irr_rd[3] == 0, "R1 cleared", irr_rd[3], 0);

    // R5 / R4 / R11: level pin 1
    cfg_level[1] = 1'b1;
    ev(1, 1); tick(); tick();
    check(msg_valid && msg_pin == 1 && rirr_set == 8'h02, "R5 level strobe", rirr_set, 8'h02);
    tick();
    check(!msg_valid && cfg_rirr[1], "R5 remote set", cfg_rirr[1], 1);
    ev(1, 1); tick(); tick();
    check(!msg_valid, "R4 remote blocks", msg_valid, 0);
    cfg_rirr[1] = 1'b0;
    tick(); tick();
    check(!msg_valid, "R4 dropped attempt stays dropped", msg_valid, 0);
    ev(1, 1); tick();
    msg_hit = 1'b0;
    tick();
    check(msg_valid && msg_pin == 1, "R11 level re-arm with IRR set", msg_pin, 1);
    check(rirr_set == 0, "R5 no strobe without hit", rirr_set, 0);
    tick();
    msg_hit = 1'b1;

    // R4 mask, R6 write re-arm on level pin 5
    cfg_level[5] = 1'b1; cfg_mask[5] = 1'b1;
    ev(5, 1); tick(); tick();
    check(!msg_valid, "R4 masked", msg_valid, 0);
    cfg_mask[5] = 1'b0; tick(); tick();
    check(!msg_valid, "R4 unmask alone does not revive", msg_valid, 0);
    cfg_wr[5] = 1'b1; tick(); tick();
    check(msg_valid && msg_pin == 5, "R6 write re-arm", msg_pin, 5);
    tick();

    // R7 ordering
    msg_ready = 1'b0;
    ev(6, 1); ev(2, 1); tick(); tick();
    check(msg_valid && msg_pin == 2, "R7 lowest first", msg_pin, 2);
    msg_ready = 1'b1; tick();
    check(msg_valid && msg_pin == 6, "R7 back-to-back", msg_pin, 6);
    tick();
    check(!msg_valid, "R7 drained", msg_valid, 0);

    // R1 cancel while output busy, R8 IRR kept
    msg_ready = 1'b0;
    ev(0, 1); tick(); tick();
    ev(7, 1); tick();
    check(irr_rd[7] == 1 && msg_pin == 0, "R8 IRR kept while held", irr_rd[7], 1);
    ev(7, 0); tick();
    msg_ready = 1'b1; tick(); tick(); tick();
    check(!msg_valid, "R1 cancelled attempt not sent", msg_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule